// File: doc/BRIEF.md
# Software-Serviced Watchdog Timer

This block watches for a stalled program. A 10-bit up-counter advances on each pulse of a one-cycle tick enable. The tick enable comes from a 256 Hz divider and is synchronous to the system clock. Software must restart the count from time to time. If it does not, the counter runs past its top value, which takes 1024 ticks or 4 seconds at 256 Hz. The block then raises a one-cycle non-maskable interrupt request, and the counter wraps to zero and keeps counting.

The watchdog runs straight out of reset with no software action. One 4-bit control register sits at a fixed address on a simple synchronous bus. Bit 1 is the enable and can be read and written. Bit 0 is a restart strobe that can only be written. The counter keeps running while the CPU is halted. The interrupt pulse is also driven on a separate wake output that ends the halt.

Top module: `svc_watchdog`

## Requirements
- R1: After synchronous reset the watchdog is enabled, a read of address 16'hFF01 returns 4'b0010, and nmi_o and halt_wake_o are low.
- R2: While enabled, the count rises by one per cycle with tick_i high. On the 1024th counted tick after a reset or restart, nmi_o is high for exactly one clock, in the cycle that follows the tick cycle.
- R3: After an overflow the count wraps to zero and keeps running. The next nmi_o pulse follows after another 1024 counted ticks.
- R4: A write to 16'hFF01 with data bit 0 = 1 clears the count to zero. A write with data bit 0 = 0 leaves the count unchanged.
- R5: When a restart write and a tick arrive in the same cycle, the restart wins and that tick is not counted.
- R6: A write to 16'hFF01 loads data bit 1 into the enable (1 = run, 0 = stop). While stopped, the count holds and no nmi_o is raised. Setting the enable again resumes from the held count.
- R7: A read of 16'hFF01 returns {2'b00, enable, 1'b0}. Bit 0 and bits 3:2 always read 0, and writes to bits 3:2 are ignored.
- R8: A write to any other address changes neither the enable nor the count. A read of any other address returns 4'b0000.
- R9: halt_wake_o carries the same pulse as nmi_o, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle 256 Hz tick enable |
| addr_i | input | 16 | Bus address |
| wr_en_i | input | 1 | Bus write strobe |
| wdata_i | input | 4 | Bus write data |
| rdata_o | output | 4 | Bus read data (combinational) |
| nmi_o | output | 1 | One-cycle non-maskable interrupt request |
| halt_wake_o | output | 1 | One-cycle halt release pulse |

## Verification
The bench counts ticks up to the exact overflow point and checks that the pulse comes on the 1024th tick and not the 1023rd. An off-by-one counter would fire one tick early or late, and a counter that saturates instead of wrapping would never fire a second time. Two cases target the restart strobe. A restart that coincides with a tick must not count that tick, or the pulse would arrive one tick early. A write of 0 to the strobe, or a strobe written to the wrong address, must not restart the count, or the pulse would be pushed out by a full period. The bench stops the counter partway through a period and checks that re-enabling resumes from the held value. A design that cleared the count on stop would fire late, and one that kept counting while stopped would fire during the stop.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int CNT_W     = 10;
    localparam int DATA_W    = 4;
    localparam int ADDR_W    = 16;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 16'hFF01;
    localparam int RUN_BIT   = 1;
    localparam int KICK_BIT  = 0;

    typedef struct packed {
        logic kick;     // clear the counter this cycle
        logic run_wr;   // load run flag this cycle
        logic run_val;  // value to load
    } ctrl_cmd_t;

    function automatic ctrl_cmd_t decode_write(input logic hit, input logic we,
                                               input logic [DATA_W-1:0] d);
        ctrl_cmd_t c;
        c.run_wr  = hit && we;
        c.run_val = d[RUN_BIT];
        c.kick    = hit && we && d[KICK_BIT];
        return c;
    endfunction
endpackage

// File: rtl/wdg_regif.sv
module wdg_regif
    import wdg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter logic [AW-1:0] REG_ADDR = CTRL_ADDR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output ctrl_cmd_t     cmd_o,
    output logic          run_o
);
    logic hit;
    logic run_q;

    assign hit   = (addr_i == REG_ADDR);
    assign cmd_o = decode_write(hit, wr_en_i, wdata_i);
    assign run_o = run_q;

    always_ff @(posedge clk) begin
        if (rst)              run_q <= 1'b1;
        else if (cmd_o.run_wr) run_q <= cmd_o.run_val;
    end

    // Read mux: only the run flag is backed by storage.
    for (genvar b = 0; b < DW; b++) begin : g_rd
        if (b == RUN_BIT) begin : g_run
            assign rdata_o[b] = hit & run_q;
        end else begin : g_zero
            assign rdata_o[b] = 1'b0;
        end
    end

    // R6: a matched write loads bit 1 into the run flag
    a_r6_run_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && hit) |=> (run_q == $past(wdata_i[RUN_BIT])));
    // R8: writes elsewhere leave the run flag alone
    a_r8_run_kept: assert property (@(posedge clk) disable iff (rst)
        !(wr_en_i && hit) |=> $stable(run_q));
endmodule

// File: rtl/wdg_count.sv
module wdg_count
    import wdg_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_i,
    input  logic      run_i,
    input  ctrl_cmd_t cmd_i,
    output logic      nmi_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic         nmi_q;
    logic         adv;

    assign adv   = run_i && tick_i && !cmd_i.kick;
    assign nmi_o = nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            nmi_q <= 1'b0;
        end else begin
            nmi_q <= 1'b0;
            if (cmd_i.kick) begin
                cnt_q <= '0;
            end else if (adv) begin
                cnt_q <= cnt_q + 1'b1;
                nmi_q <= (cnt_q == TOP);
            end
        end
    end

    // R2: the request lasts one clock
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        nmi_q |=> !nmi_q);
    // R3: the count has wrapped when the request appears
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        nmi_q |-> (cnt_q == '0));
    // R4/R5: restart clears the count, even with a tick
    a_r4_kick_clears: assert property (@(posedge clk) disable iff (rst)
        cmd_i.kick |=> (cnt_q == '0 && !nmi_q));
    // R6: stopped counter holds
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !cmd_i.kick) |=> ($stable(cnt_q) && !nmi_q));
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
    import wdg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = CNT_W,
    parameter logic [AW-1:0] REG_ADDR = CTRL_ADDR
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          nmi_o,
    output logic          halt_wake_o
);
    ctrl_cmd_t cmd;
    logic      run;

    wdg_regif #(.AW(AW), .DW(DW), .REG_ADDR(REG_ADDR)) u_regif (
        .clk(clk), .rst(rst), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .cmd_o(cmd), .run_o(run)
    );

    wdg_count #(.W(CW)) u_count (
        .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(run),
        .cmd_i(cmd), .nmi_o(nmi_o)
    );

    // R9: the wake event is the interrupt pulse itself
    assign halt_wake_o = nmi_o;

    // R6: no request without a running counter one cycle earlier
    a_r6_no_nmi_stopped: assert property (@(posedge clk) disable iff (rst)
        nmi_o |-> $past(run));
endmodule

// File: tb/tb_svc_watchdog.sv
module tb_svc_watchdog;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [15:0] REG = 16'hFF01;
    localparam logic [15:0] OTH = 16'hFF00;
    localparam int NV = 7;
    localparam logic [15:0] V_WA [NV] = '{REG, REG, OTH, REG, REG, OTH, REG};
    localparam logic [3:0]  V_WD [NV] = '{4'hF, 4'h1, 4'h2, 4'hE, 4'hC, 4'hF, 4'h2};
    localparam logic [15:0] V_RA [NV] = '{REG, REG, REG, REG, REG, OTH, REG};
    localparam logic [3:0]  V_EX [NV] = '{4'h2, 4'h0, 4'h0, 4'h2, 4'h0, 4'h0, 4'h2};

    logic clk = 0, rst = 1, tick = 0, we = 0;
    logic [15:0] addr = REG;
    logic [3:0] wd = 0;
    logic [3:0] rd;
    logic nmi, wake;
    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    svc_watchdog dut (.clk(clk), .rst(rst), .tick_i(tick), .addr_i(addr),
        .wr_en_i(we), .wdata_i(wd), .rdata_o(rd), .nmi_o(nmi), .halt_wake_o(wake));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // n ticks back to back; returns number of pulses and index of the first
    task automatic pulses(input int n, output int cnt, output int first);
        cnt = 0; first = 0;
        for (int i = 1; i <= n; i++) begin
            tick = 1;
            @(posedge clk); @(negedge clk);
            if (nmi) begin
                cnt++;
                if (first == 0) first = i;
                if (wake != nmi) chk("R9 wake", wake, nmi);
            end
        end
        tick = 0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [3:0] d);
        addr = a; wd = d; we = 1;
        @(posedge clk); @(negedge clk);
        we = 0; wd = 0;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [3:0] e);
        addr = a; #1;
        chk(req, rd, e);
    endtask

    initial begin
        int c, f;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd_chk("R1 reset read", REG, 4'h2);
        chk("R1 nmi low", nmi, 0);
        chk("R1 wake low", wake, 0);
        // R7 R8 register table
        for (int v = 0; v < NV; v++) begin
            wr(V_WA[v], V_WD[v]);
            rd_chk($sformatf("R7/R8 vec%0d", v), V_RA[v], V_EX[v]);
        end
        // R2 exact timeout
        pulses(1023, c, f); chk("R2 none before 1024", c, 0);
        pulses(1, c, f);    chk("R2 pulse on 1024th", c, 1);
        tick = 0; @(posedge clk); @(negedge clk);
        chk("R2 one clock wide", nmi, 0);
        // R3 wrap and repeat
        pulses(1024, c, f); chk("R3 second pulse count", c, 1);
        chk("R3 second pulse at 1024", f, 1024);
        // R4 restart
        pulses(600, c, f); wr(REG, 4'h3);
        pulses(1023, c, f); chk("R4 restart delays", c, 0);
        pulses(1, c, f);    chk("R4 pulse after restart", c, 1);
        // R4 write of 0 to strobe is no restart
        pulses(1023, c, f); wr(REG, 4'h2);
        pulses(1, c, f);    chk("R4 zero strobe no restart", c, 1);
        // R8 restart at wrong address ignored
        pulses(1023, c, f); wr(OTH, 4'h1);
        rd_chk("R8 other addr read", OTH, 4'h0);
        pulses(1, c, f);    chk("R8 foreign write ignored", c, 1);
        // R5 restart beats simultaneous tick
        pulses(1023, c, f);
        tick = 1; wr(REG, 4'h3); tick = 0;
        chk("R5 no pulse at collision", nmi, 0);
        pulses(1023, c, f); chk("R5 tick not counted", c, 0);
        pulses(1, c, f);    chk("R5 pulse after full period", c, 1);
        // R6 stop, hold, resume
        pulses(500, c, f); wr(REG, 4'h0);
        rd_chk("R6 read stopped", REG, 4'h0);
        pulses(2000, c, f); chk("R6 no pulse while stopped", c, 0);
        wr(REG, 4'h2);
        pulses(523, c, f); chk("R6 resume from held", c, 0);
        pulses(1, c, f);   chk("R6 pulse at held+rest", c, 1);
        // R1 mid-run reset
        pulses(700, c, f);
        rst = 1; @(posedge clk); @(negedge clk); rst = 0;
        rd_chk("R1 reset read again", REG, 4'h2);
        pulses(1023, c, f); chk("R1 count cleared by reset", c, 0);
        pulses(1, c, f);    chk("R1 runs after reset", c, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule